// File: doc/BRIEF.md
# Signed Binary to Residue Converter

This block turns a 32-bit two's-complement integer into a 33-bit residue word. The word has three channels. One channel is modulo 2^16 and is 16 bits wide. The other two are modulo 255 and modulo 257, and they are 8 and 9 bits wide. The three moduli are pairwise co-prime. Their product M = 2^32 − 2^16 is the dynamic range of the residue word, so the signed values it can represent lie in [−M/2, M/2).

Conversion takes two steps. First, the input is clamped into that signed window. Negative values are then folded upward by adding M. Second, the folded 32-bit word is cut into four bytes, and each residue is reduced from those bytes. Inputs travel with a valid flag through a two-stage pipeline, so a result appears two clock edges after its operand.

The 2^16 channel sits in the low bits of the output, so those bits can be read directly as an unsigned binary number.

Top module: `b2r_conv`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` and `out_res` are cleared to 0 on that edge, whatever `in_valid` and `in_word` carry.
- R2: `out_valid` is high exactly two rising edges after an edge at which `in_valid` was sampled high. It is low after an edge two cycles after one at which `in_valid` was low.
- R3: When `out_valid` is high, `out_res[15:0]` equals the clamped input value reduced modulo 65536 into 0..65535.
- R4: When `out_valid` is high, `out_res[23:16]` equals the clamped value reduced modulo 255. It is always in 0..254 and never reads 255.
- R5: When `out_valid` is high, `out_res[32:24]` equals the clamped value reduced modulo 257, in 0..256.
- R6: An input at or above M/2 = 2147450880 is treated as M/2 − 1 = 2147450879.
- R7: An input below −M/2 = −2147450880 is treated as −M/2.
- R8: An in-range negative input x produces the residues of x + M. This is the same as the non-negative remainder of x in each channel.
- R9: `out_res` keeps its previous value across any edge at which no result is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_word` carries an operand this cycle |
| in_word | input | 32 | Two's-complement operand |
| out_valid | output | 1 | `out_res` carries a result this cycle |
| out_res | output | 33 | Residues: [32:24] mod 257, [23:16] mod 255, [15:0] mod 65536 |

## Verification
The assertions assume the following about the inputs:
- `in_valid` is a clean 0 or 1 at every sampled edge.
- Reset is held for at least one edge before operation starts.

They make no assumption about `in_word`. The range checks on the two odd channels must therefore hold for every bit pattern.

The stimulus stays inside these assumptions. It drives inputs only on falling edges and keeps reset low for several edges. It covers every small value from −600 to 600 and the 601-value windows around both saturation thresholds. It adds the extreme 32-bit values and a long pseudo-random stream with idle gaps. In each channel, the expected results come from plain remainder arithmetic on the clamped value.

// File: rtl/b2r_pkg.sv
// Shared defaults for the binary to residue converter.
// Assumes the channel width is a small positive integer and the input word is four channels wide.
package b2r_pkg;
    parameter int unsigned DEF_CHUNK_W = 8;   // width n of the two odd channels
    parameter int unsigned DEF_CHUNKS  = 4;   // input word is DEF_CHUNKS * n bits wide

    // Pipeline stage record: a valid flag with its word.
    typedef struct packed {
        logic        valid;
        logic [31:0] word;
    } stage_t;
endpackage

// File: rtl/b2r_clamp_fold.sv
// Clamps a signed word into [-M/2, M/2) and folds negatives up by M.
// Purely combinational. Assumes M = 2^(4n) - 2^(2n), which fits in the input width.
module b2r_clamp_fold #(
    parameter int unsigned N = 8
) (
    input  logic [4*N-1:0] x_in,
    output logic [4*N-1:0] adapted,
    output logic           sat_hi,
    output logic           sat_lo
);
    localparam int unsigned W = 4 * N;
    localparam logic [W-1:0] ONE      = W'(1);
    localparam logic [W-1:0] HALF_MAG = (ONE << (W - 1)) - (ONE << (2 * N - 1));
    localparam logic [W-1:0] RANGE_M  = HALF_MAG << 1;
    localparam logic [W-1:0] POS_MAX  = HALF_MAG - ONE;
    localparam logic [W-1:0] NEG_MIN  = (~HALF_MAG) + ONE;

    logic [W-1:0] clamped;

    // Two magnitude comparators select the saturation case.
    always_comb begin
        sat_hi = $signed(x_in) >= $signed(HALF_MAG);
        sat_lo = $signed(x_in) <  $signed(NEG_MIN);
    end

    // One multiplexer picks the clamped value; the fold adds M to negatives.
    always_comb begin
        if (sat_hi)      clamped = POS_MAX;
        else if (sat_lo) clamped = NEG_MIN;
        else             clamped = x_in;
        adapted = clamped[W-1] ? (clamped + RANGE_M) : clamped;
    end
endmodule

// File: rtl/b2r_mod_dim.sv
// Reduces a word modulo 2^n - 1 by summing its n-bit chunks with end-around carry.
// The result is normalised to 0 .. 2^n - 2. Combinational. Assumes CHUNKS >= 2.
module b2r_mod_dim #(
    parameter int unsigned N      = 8,
    parameter int unsigned CHUNKS = 4
) (
    input  logic [N*CHUNKS-1:0] word,
    output logic [N-1:0]        res
);
    localparam int unsigned SW    = N + $clog2(CHUNKS) + 1;
    localparam int unsigned FOLDS = 3;

    logic [N-1:0]  chunk [CHUNKS];
    logic [SW-1:0] acc;

    // Slice the word into n-bit chunks.
    for (genvar g = 0; g < CHUNKS; g++) begin : g_slice
        assign chunk[g] = word[g*N +: N];
    end

    // Sum the chunks, then fold the high part back in, since 2^n = 1 (mod 2^n - 1).
    always_comb begin
        acc = '0;
        for (int i = 0; i < CHUNKS; i++) acc = acc + SW'(chunk[i]);
        for (int k = 0; k < FOLDS; k++) acc = SW'(acc[N-1:0]) + (acc >> N);
        res = (acc[N-1:0] == {N{1'b1}}) ? '0 : acc[N-1:0];
    end
endmodule

// File: rtl/b2r_mod_ext.sv
// Reduces a word modulo 2^n + 1 as an alternating sum of its n-bit chunks.
// Even chunks add and odd chunks subtract, since 2^n = -1 (mod 2^n + 1).
// The result is normalised to 0 .. 2^n. Combinational. Assumes CHUNKS is even.
module b2r_mod_ext #(
    parameter int unsigned N      = 8,
    parameter int unsigned CHUNKS = 4
) (
    input  logic [N*CHUNKS-1:0] word,
    output logic [N:0]          res
);
    localparam int unsigned SW = N + $clog2(CHUNKS) + 2;
    localparam logic [SW-1:0] P    = SW'((1 << N) + 1);
    localparam logic [SW-1:0] BIAS = SW'((CHUNKS / 2) * ((1 << N) + 1));

    logic [N-1:0]  chunk [CHUNKS];
    logic [SW-1:0] pos_sum;
    logic [SW-1:0] neg_sum;
    logic [SW-1:0] v;

    // Slice the word into n-bit chunks.
    for (genvar g = 0; g < CHUNKS; g++) begin : g_slice
        assign chunk[g] = word[g*N +: N];
    end

    // Collect even and odd chunk sums separately.
    always_comb begin
        pos_sum = '0;
        neg_sum = '0;
        for (int i = 0; i < CHUNKS; i++) begin
            if ((i % 2) == 0) pos_sum = pos_sum + SW'(chunk[i]);
            else              neg_sum = neg_sum + SW'(chunk[i]);
        end
    end

    // Form a biased difference, fold twice with a modulus bias, then subtract P at most once.
    always_comb begin
        v = pos_sum + BIAS - neg_sum;
        for (int k = 0; k < 2; k++) v = SW'(v[N-1:0]) + P - (v >> N);
        if (v >= P) v = v - P;
        res = v[N:0];
    end
endmodule

// File: rtl/b2r_conv.sv
// Two-stage signed binary to residue converter.
// Stage 1 clamps and folds the operand. Stage 2 reduces the folded word into the three channels.
// Output layout: [top 9 bits] mod 2^n+1, [next 8] mod 2^n-1, [low 2n] mod 2^2n.
// Assumes a synchronous active-low reset. Data registers load only with a valid flag.
module b2r_conv #(
    parameter int unsigned N = b2r_pkg::DEF_CHUNK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [4*N-1:0]   in_word,
    output logic             out_valid,
    output logic [4*N:0]     out_res
);
    localparam int unsigned IN_W   = 4 * N;
    localparam int unsigned OUT_W  = IN_W + 1;
    localparam int unsigned CHUNKS = 4;
    localparam int unsigned BIN_W  = 2 * N;

    logic [IN_W-1:0] adapted;
    logic            sat_hi;
    logic            sat_lo;
    logic            s1_valid;
    logic [IN_W-1:0] s1_word;
    logic [N-1:0]    r_dim;
    logic [N:0]      r_ext;

    b2r_clamp_fold #(.N(N)) u_clamp (
        .x_in    (in_word),
        .adapted (adapted),
        .sat_hi  (sat_hi),
        .sat_lo  (sat_lo)
    );

    // Stage 1 register: hold the folded operand and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_word  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) s1_word <= adapted;
        end
    end

    b2r_mod_dim #(.N(N), .CHUNKS(CHUNKS)) u_dim (
        .word (s1_word),
        .res  (r_dim)
    );

    b2r_mod_ext #(.N(N), .CHUNKS(CHUNKS)) u_ext (
        .word (s1_word),
        .res  (r_ext)
    );

    // Stage 2 register: pack the three channels; hold the word between results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) out_res <= {r_ext, r_dim, s1_word[BIN_W-1:0]};
        end
    end

    logic unused_sat;
    assign unused_sat = sat_hi ^ sat_lo;
endmodule

// File: rtl/b2r_conv_chk.sv
// Property checker for b2r_conv, attached with a bind statement.
// Assumes in_valid is never unknown at a sampled edge.
module b2r_conv_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         s1_valid,
    input logic         out_valid,
    input logic [4*N:0] out_res
);
    localparam int unsigned HI = 4 * N;

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!out_valid && out_res == '0));   // R1
    AST_LAT_HIGH:   assert property (@(posedge clk) disable iff (!rst_n) s1_valid |=> out_valid);  // R2
    AST_LAT_LOW:    assert property (@(posedge clk) disable iff (!rst_n) !s1_valid |=> !out_valid); // R2
    AST_DIM_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_res[HI-N-1 -: N] != {N{1'b1}})); // R4
    AST_EXT_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_res[HI -: N+1] <= (N+1)'((1 << N) + 1) - 1'b1)); // R5
    AST_HOLD_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) !s1_valid |=> $stable(out_res)); // R9
endmodule

bind b2r_conv b2r_conv_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .out_valid (out_valid),
    .out_res   (out_res)
);

// File: tb/b2r_conv_bench.sv
module b2r_conv_bench;
    localparam longint HALF = 64'd2147450880;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [32:0] out_res;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic        pend_v [2];
    logic [32:0] pend_w [2];
    string       pend_t [2];
    logic [32:0] prev_res = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    b2r_conv u_b2r_conv (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_word (in_word),
        .out_valid (out_valid), .out_res (out_res)
    );

    function automatic longint clamp_ref(logic [31:0] w);
        longint x = longint'($signed(w));
        if (x >= HALF) return HALF - 1;
        if (x < -HALF) return -HALF;
        return x;
    endfunction

    function automatic longint rmod(longint x, longint m);
        return ((x % m) + m) % m;
    endfunction

    function automatic logic [32:0] pack_ref(logic [31:0] w);
        longint s = clamp_ref(w);
        return {9'(rmod(s, 257)), 8'(rmod(s, 255)), 16'(rmod(s, 65536))};
    endfunction

    function automatic string class_tag(logic [31:0] w);
        longint x = longint'($signed(w));
        if (x >= HALF) return "R6";
        if (x < -HALF) return "R7";
        if (x < 0)     return "R8";
        return "in-range";
    endfunction

    task automatic check(bit ok, string req, logic [32:0] act, logic [32:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One falling-edge step: compare the output due now, then drive the next operand.
    task automatic step(bit v, logic [31:0] w);
        @(negedge clk);
        check(out_valid == pend_v[1], "R2 out_valid", 33'(out_valid), 33'(pend_v[1]));
        if (pend_v[1] && out_valid) begin
            check(out_res[15:0]  == pend_w[1][15:0],  {"R3 ", pend_t[1]}, out_res, pend_w[1]);
            check(out_res[23:16] == pend_w[1][23:16], {"R4 ", pend_t[1]}, out_res, pend_w[1]);
            check(out_res[32:24] == pend_w[1][32:24], {"R5 ", pend_t[1]}, out_res, pend_w[1]);
        end else if (!out_valid) begin
            check(out_res == prev_res, "R9 hold", out_res, prev_res);
        end
        prev_res  = out_res;
        pend_v[1] = pend_v[0];
        pend_w[1] = pend_w[0];
        pend_t[1] = pend_t[0];
        pend_v[0] = v;
        pend_w[0] = pack_ref(w);
        pend_t[0] = class_tag(w);
        in_valid  = v;
        in_word   = w;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        pend_v[0] = 1'b0; pend_v[1] = 1'b0;
        pend_w[0] = '0;   pend_w[1] = '0;
        pend_t[0] = "";   pend_t[1] = "";
        // R1: reset clears the outputs despite active inputs.
        in_valid = 1'b1;
        in_word  = 32'hDEAD_BEEF;
        repeat (4) begin
            @(negedge clk);
            check(!out_valid && out_res == '0, "R1 reset", out_res, 33'd0);
        end
        in_valid = 1'b0;
        rst_n    = 1'b1;
        prev_res = '0;
        // Corner values: zero, ±1, channel edges, both saturation thresholds, 32-bit extremes.
        step(1, 32'd0);            step(1, 32'd1);           step(1, 32'hFFFF_FFFF);
        step(1, 32'd255);          step(1, 32'd256);         step(1, 32'd257);
        step(1, -32'sd255);        step(1, -32'sd256);       step(1, -32'sd257);
        step(1, 32'd65535);        step(1, 32'd65536);       step(1, -32'sd65536);
        step(1, 32'd2147450879);   step(1, 32'd2147450880);  step(1, 32'd2147450881); // R6
        step(1, 32'h7FFF_FFFF);    step(1, -32'sd2147450880);                         // R6, R7
        step(1, -32'sd2147450881); step(1, 32'h8000_0000);                            // R7
        step(0, 32'd0); step(0, 32'd0); step(0, 32'd0);                               // R9
        // Full small-value sweep across zero (R8 for negatives).
        for (int i = -600; i <= 600; i++) step(1, 32'(i));
        // Windows around each saturation threshold.
        for (int i = -300; i <= 300; i++) step(1, 32'(HALF + i));
        for (int i = -300; i <= 300; i++) step(1, 32'(-HALF + i));
        // Pseudo-random stream with periodic idle cycles.
        for (int i = 0; i < 20000; i++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            step((i % 7) != 3, lfsr);
        end
        step(0, 32'd0); step(0, 32'd0); step(0, 32'd0);
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule